// File: doc/BRIEF.md
# Two-Stage Lockable Watchdog Timer

This block is a memory-mapped watchdog built around a down-counter. When the counter first runs out, it raises an interrupt and reloads itself for a second countdown. If that second countdown also runs out before software has cleared the interrupt, and the reset output is enabled, the block requests a system reset. The reset request stays asserted until the block itself is reset.

Software keeps the system alive by writing to the interrupt-clear register. Any such write drops the interrupt and restarts the countdown from the load value.

A key register guards the load, control and interrupt-clear registers against stray writes. Writing the 32-bit key 0x1ACCE551 opens them. Any other value closes them again. Access uses a plain single-cycle port: address, write strobe and write data in, and registered read data out.

Top module: `twostage_wdog`

## Requirements
- R1: After reset, the load and value registers read 0xFFFFFFFF, control reads 0, the raw status reads 0, the lock register reads 0 (unlocked), and both `irq_o` and `rst_req_o` are low.
- R2: With control bit 0 set and load value L, `irq_o` rises exactly L+1 clock edges after the control write. At that point the counter reloads L.
- R3: With control bits 0 and 1 set, `rst_req_o` rises 2·(L+1) edges after the enabling write if no clear occurs. It stays high until the block is reset.
- R4: Any write to the clear register (0x00C) clears the raw flag and reloads the counter from the load value. Clears repeated before each expiry keep both `irq_o` and `rst_req_o` low.
- R5: Control bit 1 gates the reset. With only bit 0 set, the second expiry causes no reset, the flag stays set, and counting continues.
- R6: Raw status (0x010, bit 0) shows the flag. Masked status (0x014, bit 0) and `irq_o` equal the flag ANDed with control bit 0.
- R7: Writing 0x1ACCE551 to 0xC00 unlocks and any other value locks. The lock register reads 1 when locked. While locked, writes to load, control and clear change nothing.
- R8: A load write (0x000) sets the counter immediately. With load 0 written while running and the flag clear, `irq_o` rises on the next edge and `rst_req_o` on the edge after.
- R9: Clearing control bit 0 freezes the counter at its value. Setting it again restarts the count from the load value.
- R10: `bus_rdata` returns, one edge after the address is presented, the register at that address: load 0x000, current value 0x004, control bits [1:0] at 0x008.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address of the register |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Masked interrupt |
| rst_req_o | output | 1 | Sticky system reset request |

## Verification
The bench pins down the exact edge on which each expiry stage fires. A design that is off by one in the reload, or that counts the zero state twice, shifts `irq_o` or `rst_req_o` by a cycle.

It clears the flag just before each expiry would happen. A design that forgot to reload on clear would still reach reset.

It runs with only interrupt enable set, to catch a reset that ignores its enable bit. It also attempts every guarded write while locked, including a clear while the flag is pending; a leaky lock would change the read-back value or drop the flag.

Finally, it loads zero while running and checks that the count freezes on disable and restarts from the load value on re-enable.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 12;
  localparam logic [ADDR_W-1:0] OFS_LOAD  = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_VALUE = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_CLEAR = 12'h00C;
  localparam logic [ADDR_W-1:0] OFS_RAW   = 12'h010;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 12'h014;
  localparam logic [ADDR_W-1:0] OFS_KEY   = 12'hC00;
  localparam logic [DATA_W-1:0] OPEN_KEY  = 32'h1ACCE551;
endpackage

// File: rtl/wdog_access.sv
module wdog_access
  import wdog_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [CNT_W-1:0]  load_q,
  input  logic [CNT_W-1:0]  cnt_q,
  input  logic              run_q,
  input  logic              rsten_q,
  input  logic              flag_q,
  output logic              wr_load,
  output logic              wr_ctrl,
  output logic              wr_clear,
  output logic              locked_q,
  output logic [DATA_W-1:0] rdata_q
);
  logic open_w;

  assign open_w   = ~locked_q;
  assign wr_load  = bus_we && open_w && (bus_addr == OFS_LOAD);
  assign wr_ctrl  = bus_we && open_w && (bus_addr == OFS_CTRL);
  assign wr_clear = bus_we && open_w && (bus_addr == OFS_CLEAR);

  // key register: always writable
  always_ff @(posedge clk) begin
    if (rst) begin
      locked_q <= 1'b0;
    end else if (bus_we && (bus_addr == OFS_KEY)) begin
      locked_q <= (bus_wdata != OPEN_KEY);
    end
  end

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      OFS_LOAD:  rd_mux = DATA_W'(load_q);
      OFS_VALUE: rd_mux = DATA_W'(cnt_q);
      OFS_CTRL:  rd_mux = DATA_W'({rsten_q, run_q});
      OFS_RAW:   rd_mux = DATA_W'(flag_q);
      OFS_MASK:  rd_mux = DATA_W'(flag_q & run_q);
      OFS_KEY:   rd_mux = DATA_W'(locked_q);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_mux;
  end
endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_load,
  input  logic              wr_ctrl,
  input  logic              wr_clear,
  input  logic [DATA_W-1:0] wdata,
  output logic [CNT_W-1:0]  load_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              run_q,
  output logic              rsten_q,
  output logic              flag_q,
  output logic              rreq_q
);
  localparam logic [CNT_W-1:0] CNT_ONES = '1;
  logic at_zero;

  assign at_zero = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      load_q  <= CNT_ONES;
      cnt_q   <= CNT_ONES;
      run_q   <= 1'b0;
      rsten_q <= 1'b0;
      flag_q  <= 1'b0;
      rreq_q  <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        run_q   <= wdata[0];
        rsten_q <= wdata[1];
      end
      if (wr_load) begin
        load_q <= wdata[CNT_W-1:0];
        cnt_q  <= wdata[CNT_W-1:0];
      end else if (wr_clear) begin
        cnt_q  <= load_q;
        flag_q <= 1'b0;
      end else if (wr_ctrl && wdata[0] && !run_q) begin
        cnt_q <= load_q;
      end else if (run_q) begin
        if (at_zero) begin
          cnt_q <= load_q;
          if (!flag_q)      flag_q <= 1'b1;
          else if (rsten_q) rreq_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/twostage_wdog.sv
module twostage_wdog
  import wdog_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [11:0] bus_addr,
  input  logic        bus_we,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq_o,
  output logic        rst_req_o
);
  logic             wr_load, wr_ctrl, wr_clear, locked_q;
  logic [CNT_W-1:0] load_q, cnt_q;
  logic             run_q, rsten_q, flag_q, rreq_q;

  wdog_access #(.CNT_W(CNT_W)) u_access (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .load_q(load_q), .cnt_q(cnt_q), .run_q(run_q),
    .rsten_q(rsten_q), .flag_q(flag_q), .wr_load(wr_load),
    .wr_ctrl(wr_ctrl), .wr_clear(wr_clear), .locked_q(locked_q),
    .rdata_q(bus_rdata)
  );

  wdog_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .wr_load(wr_load), .wr_ctrl(wr_ctrl),
    .wr_clear(wr_clear), .wdata(bus_wdata), .load_q(load_q),
    .cnt_q(cnt_q), .run_q(run_q), .rsten_q(rsten_q), .flag_q(flag_q),
    .rreq_q(rreq_q)
  );

  assign irq_o     = flag_q & run_q;
  assign rst_req_o = rreq_q;
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_we,
  input logic [11:0]      bus_addr,
  input logic             locked_q,
  input logic [CNT_W-1:0] load_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             run_q,
  input logic             rsten_q,
  input logic             flag_q,
  input logic             rst_req_o
);
  // R3: reset request holds once raised
  a_r3_reset_sticky: assert property (@(posedge clk) disable iff (rst)
    rst_req_o |=> rst_req_o);

  // R3 / R5: reset only follows a pending flag with reset enabled
  a_r3_reset_needs_flag: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_req_o) |-> ($past(flag_q) && $past(rsten_q) && $past(cnt_q) == '0));

  // R2: flag only rises from an expiry of a running counter
  a_r2_flag_from_expiry: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> ($past(run_q) && $past(cnt_q) == '0));

  // R7: locked load writes change nothing
  a_r7_locked_load_hold: assert property (@(posedge clk) disable iff (rst)
    (bus_we && locked_q && bus_addr == 12'h000) |=> $stable(load_q));

  // R9: stopped counter holds its value without writes
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !bus_we) |=> $stable(cnt_q));
endmodule

bind twostage_wdog wdog_checker #(.CNT_W(CNT_W)) u_wdog_checker (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
  .locked_q(locked_q), .load_q(load_q), .cnt_q(cnt_q), .run_q(run_q),
  .rsten_q(rsten_q), .flag_q(flag_q), .rst_req_o(rst_req_o)
);

// File: tb/test_twostage_wdog.sv
module test_twostage_wdog;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, rst_req_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  twostage_wdog i_twostage_wdog (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o),
    .rst_req_o(rst_req_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // all tasks are entered and left just after a falling edge
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; bus_we = 1'b0;
    wait_n(3);
    rst = 1'b0;
  endtask

  task automatic t_reset_state();
    logic [31:0] v;
    do_reset();
    check("R1 irq", {31'b0, irq_o}, 32'd0);
    check("R1 rst_req", {31'b0, rst_req_o}, 32'd0);
    rd(12'h000, v); check("R1 load", v, 32'hFFFFFFFF);
    rd(12'h004, v); check("R1 value", v, 32'hFFFFFFFF);
    rd(12'h008, v); check("R1 ctrl", v, 32'd0);
    rd(12'h010, v); check("R1 raw", v, 32'd0);
    rd(12'hC00, v); check("R1 lock", v, 32'd0);
  endtask

  task automatic t_two_stage();
    logic [31:0] v;
    do_reset();
    wr(12'h000, 32'd5);
    wr(12'h008, 32'd3);
    rd(12'h008, v); check("R10 ctrl readback", v, 32'd3);
    wait_n(4);  // 5 edges after enable
    check("R2 irq before L+1", {31'b0, irq_o}, 32'd0);
    wait_n(1);
    check("R2 irq at L+1", {31'b0, irq_o}, 32'd1);
    wait_n(5);  // 11 edges
    check("R3 no reset before 2(L+1)", {31'b0, rst_req_o}, 32'd0);
    wait_n(1);
    check("R3 reset at 2(L+1)", {31'b0, rst_req_o}, 32'd1);
    wait_n(20);
    check("R3 reset sticky", {31'b0, rst_req_o}, 32'd1);
  endtask

  task automatic t_ping();
    do_reset();
    wr(12'h000, 32'd5);
    wr(12'h008, 32'd3);
    wait_n(7);
    check("R4 irq pending", {31'b0, irq_o}, 32'd1);
    wr(12'h00C, 32'd0);
    check("R4 clear drops irq", {31'b0, irq_o}, 32'd0);
    for (int i = 0; i < 3; i++) begin
      wait_n(4);
      wr(12'h00C, 32'hDEAD);
    end
    check("R4 kept alive irq", {31'b0, irq_o}, 32'd0);
    check("R4 kept alive reset", {31'b0, rst_req_o}, 32'd0);
    wait_n(5);
    check("R4 reload irq early", {31'b0, irq_o}, 32'd0);
    wait_n(1);
    check("R4 reload irq on time", {31'b0, irq_o}, 32'd1);
  endtask

  task automatic t_irq_only();
    logic [31:0] v;
    do_reset();
    wr(12'h000, 32'd3);
    wr(12'h008, 32'd1);
    wait_n(12);
    check("R5 no reset without bit1", {31'b0, rst_req_o}, 32'd0);
    check("R5 irq held", {31'b0, irq_o}, 32'd1);
    rd(12'h010, v); check("R6 raw set", v, 32'd1);
    rd(12'h014, v); check("R6 masked set", v, 32'd1);
    wr(12'h008, 32'd0);
    check("R6 irq masked", {31'b0, irq_o}, 32'd0);
    rd(12'h010, v); check("R6 raw kept", v, 32'd1);
    rd(12'h014, v); check("R6 masked clear", v, 32'd0);
  endtask

  task automatic t_lock();
    logic [31:0] v;
    do_reset();
    wr(12'hC00, 32'd1);
    rd(12'hC00, v); check("R7 lock reads 1", v, 32'd1);
    wr(12'h000, 32'h55);
    rd(12'h000, v); check("R7 locked load", v, 32'hFFFFFFFF);
    wr(12'h008, 32'd3);
    rd(12'h008, v); check("R7 locked ctrl", v, 32'd0);
    wr(12'hC00, 32'h1ACCE551);
    rd(12'hC00, v); check("R7 unlock reads 0", v, 32'd0);
    wr(12'h000, 32'd2);
    wr(12'h008, 32'd1);
    wait_n(5);
    wr(12'hC00, 32'h1ACCE550);
    wr(12'h00C, 32'd0);
    rd(12'h010, v); check("R7 locked clear ignored", v, 32'd1);
    wr(12'hC00, 32'h1ACCE551);
    wr(12'h000, 32'd7);
    rd(12'h000, v); check("R7 unlocked load", v, 32'd7);
  endtask

  task automatic t_load_zero();
    do_reset();
    wr(12'h000, 32'd10);
    wr(12'h008, 32'd3);
    wait_n(3);
    wr(12'h000, 32'd0);
    check("R8 no irq yet", {31'b0, irq_o}, 32'd0);
    wait_n(1);
    check("R8 irq next edge", {31'b0, irq_o}, 32'd1);
    check("R8 reset not yet", {31'b0, rst_req_o}, 32'd0);
    wait_n(1);
    check("R8 reset edge after", {31'b0, rst_req_o}, 32'd1);
  endtask

  task automatic t_pause();
    logic [31:0] v;
    do_reset();
    wr(12'h000, 32'd20);
    wr(12'h008, 32'd3);
    wait_n(5);
    wr(12'h008, 32'd0);
    rd(12'h004, v); check("R9 frozen value", v, 32'd14);
    wait_n(6);
    rd(12'h004, v); check("R9 still frozen", v, 32'd14);
    wr(12'h008, 32'd3);
    rd(12'h004, v); check("R9 restart from load", v, 32'd20);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset_state();
    t_two_stage();
    t_ping();
    t_irq_only();
    t_lock();
    t_load_zero();
    t_pause();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule